// File: doc/BRIEF.md
# Byte-Swapping IDE Register Window

This block sits between a big-endian host bus and an IDE task-file register set. The host sees a 4 KB memory window. Each access carries a size code (byte, halfword or word) and an address. The block turns the address into a register index, with one register every 16 bytes. It then routes the access to one of three targets: the seven task-file registers, the control/status pair, or the data port. Any access that matches no target is absorbed. Such a read returns all ones and such a write is dropped.

The registers themselves live outside the block. The block produces a strobe for the chosen target and presents the write data, already lane-adjusted, on `dev_wdata_o`. It then takes the register value back on `dev_rdata_i` in the same cycle. Data-port values are byte-reversed in both directions, so the little-endian drive data appears in host order. The block registers each read result and presents it one cycle after the request.

Top module: `ide_swap_window`

## Requirements
- R1: The register index is address bits [11:4]. Address bits above bit 11 and below bit 4 do not affect decode.
- R2: A byte access (size code 0) at index 1 to 7 pulses `tf_wr_o` or `tf_rd_o` with `tf_idx_o` equal to the index. A write presents `{24'h0, wdata_i[7:0]}`. A read returns `{24'h0, dev_rdata_i[7:0]}`.
- R3: A byte write at index 8 or index 22 pulses `ctl_wr_o`. A byte read at those indices pulses `alt_rd_o` and never pulses `tf_rd_o`.
- R4: A byte read at any other index, index 0 included, returns 32'h000000FF. A byte write there raises no strobe.
- R5: Halfword (size code 1) and word (size code 2) accesses at index 0 pulse `dp_wr_o` or `dp_rd_o`. `dp_wide_o` is high for a word access and low for a halfword access.
- R6: A halfword or word access at a nonzero index raises no strobe. Such a read returns 32'h0000FFFF for a halfword and 32'hFFFFFFFF for a word.
- R7: Halfword data-port values are byte-swapped on the low 16 bits in both directions, with the upper 16 bits zero.
- R8: Word data-port values have all four bytes reversed in both directions.
- R9: Size code 3 raises no strobe at any index, and a read with it returns 32'hFFFFFFFF.
- R10: A read request sets `rvalid_o` and `rdata_o` in the next cycle. `rdata_o` changes only after a read.
- R11: While reset is active, `rvalid_o` and `rdata_o` are zero.
- R12: At most one target strobe is high at a time, and none is high without `req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| addr_i | input | ADDR_W | Host byte address |
| wdata_i | input | 32 | Host write data, right-justified |
| rvalid_o | output | 1 | Read result valid |
| rdata_o | output | 32 | Read result, right-justified |
| tf_wr_o | output | 1 | Task-file register write strobe |
| tf_rd_o | output | 1 | Task-file register read strobe |
| tf_idx_o | output | 3 | Task-file register number, 1 to 7 |
| ctl_wr_o | output | 1 | Device-control write strobe |
| alt_rd_o | output | 1 | Alternate-status read strobe |
| dp_wr_o | output | 1 | Data-port write strobe |
| dp_rd_o | output | 1 | Data-port read strobe |
| dp_wide_o | output | 1 | Data-port access is 32-bit |
| dev_wdata_o | output | 32 | Write data toward the registers |
| dev_rdata_i | input | 32 | Read data from the selected register |

## Verification
The properties assume the host presents each access as a single-cycle `req_i` pulse with stable fields. They also assume `dev_rdata_i` answers combinationally in the same cycle as the strobe. The stimulus drives every access for exactly one cycle, away from the clock edge. A bench responder keeps the task-file bytes, the control byte and the last data-port write, and it returns fixed data-port patterns, so expected results follow from the requirements alone. The addresses cover both control aliases, index 0 at byte width, high address bits and offsets inside a stride, the top index, and the reserved size code.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_TF   = 2'd1,
    TGT_CTL  = 2'd2,
    TGT_DATA = 2'd3
  } target_e;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_BYTES = DATA_W / BYTE_W;
endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
  import ide_win_pkg::*;
#(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned CTL_A   = 8,
  parameter int unsigned CTL_B   = 22,
  parameter int unsigned TF_LAST = 7
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       size_i,
  output target_e          tgt_o
);
  always_comb begin
    tgt_o = TGT_NONE;
    unique case (size_i)
      SZ_BYTE: begin
        if (idx_i >= IDX_W'(1) && idx_i <= IDX_W'(TF_LAST))
          tgt_o = TGT_TF;
        else if (idx_i == IDX_W'(CTL_A) || idx_i == IDX_W'(CTL_B))
          tgt_o = TGT_CTL;
      end
      SZ_HALF, SZ_WORD: begin
        if (idx_i == '0) tgt_o = TGT_DATA;
      end
      default: tgt_o = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/ide_win_swap.sv
module ide_win_swap
  import ide_win_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned HALF_B = N_BYTES / 2;

  logic [DATA_W-1:0]   rev_word;
  logic [DATA_W/2-1:0] rev_half;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_word
    assign rev_word[b*BYTE_W +: BYTE_W] = data_i[(N_BYTES-1-b)*BYTE_W +: BYTE_W];
  end
  for (genvar b = 0; b < HALF_B; b++) begin : g_half
    assign rev_half[b*BYTE_W +: BYTE_W] = data_i[(HALF_B-1-b)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    unique case (size_i)
      SZ_HALF: data_o = {{(DATA_W/2){1'b0}}, rev_half};
      SZ_WORD: data_o = rev_word;
      default: data_o = {{(DATA_W-BYTE_W){1'b0}}, data_i[BYTE_W-1:0]};
    endcase
  end
endmodule

// File: rtl/ide_swap_window.sv
module ide_swap_window
  import ide_win_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_BITS  = 12,
  parameter int unsigned STRIDE_LG = 4,
  parameter int unsigned CTL_A     = 8,
  parameter int unsigned CTL_B     = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o,
  output logic              tf_wr_o,
  output logic              tf_rd_o,
  output logic [2:0]        tf_idx_o,
  output logic              ctl_wr_o,
  output logic              alt_rd_o,
  output logic              dp_wr_o,
  output logic              dp_rd_o,
  output logic              dp_wide_o,
  output logic [31:0]       dev_wdata_o,
  input  logic [31:0]       dev_rdata_i
);
  localparam int unsigned IDX_W = WIN_BITS - STRIDE_LG;

  logic [IDX_W-1:0]  idx;
  target_e           tgt;
  logic [DATA_W-1:0] wr_lane, rd_lane, ones_val, rd_next;
  logic              rd_req;

  assign idx = addr_i[WIN_BITS-1:STRIDE_LG];

  ide_win_decode #(
    .IDX_W(IDX_W), .CTL_A(CTL_A), .CTL_B(CTL_B), .TF_LAST(7)
  ) u_dec (
    .idx_i(idx), .size_i(size_i), .tgt_o(tgt)
  );

  // same lane logic serves both directions; byte path only zero-extends
  ide_win_swap u_wswap (.size_i(size_i), .data_i(wdata_i),     .data_o(wr_lane));
  ide_win_swap u_rswap (.size_i(size_i), .data_i(dev_rdata_i), .data_o(rd_lane));

  assign tf_wr_o     = req_i &  we_i & (tgt == TGT_TF);
  assign tf_rd_o     = req_i & ~we_i & (tgt == TGT_TF);
  assign ctl_wr_o    = req_i &  we_i & (tgt == TGT_CTL);
  assign alt_rd_o    = req_i & ~we_i & (tgt == TGT_CTL);
  assign dp_wr_o     = req_i &  we_i & (tgt == TGT_DATA);
  assign dp_rd_o     = req_i & ~we_i & (tgt == TGT_DATA);
  assign dp_wide_o   = (size_i == SZ_WORD);
  assign tf_idx_o    = idx[2:0];
  assign dev_wdata_o = wr_lane;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: ones_val = 32'h0000_00FF;
      SZ_HALF: ones_val = 32'h0000_FFFF;
      default: ones_val = 32'hFFFF_FFFF;
    endcase
    rd_next = (tgt == TGT_NONE) ? ones_val : rd_lane;
  end

  assign rd_req = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= rd_next;
    end
  end
endmodule

// File: rtl/ide_swap_window_chk.sv
module ide_swap_window_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [1:0]  size_i,
  input logic [31:0] addr_i,
  input logic        rvalid_o,
  input logic [31:0] rdata_o,
  input logic        tf_wr_o,
  input logic        tf_rd_o,
  input logic        ctl_wr_o,
  input logic        alt_rd_o,
  input logic        dp_wr_o,
  input logic        dp_rd_o
);
  logic [5:0] strb;
  assign strb = {tf_wr_o, tf_rd_o, ctl_wr_o, alt_rd_o, dp_wr_o, dp_rd_o};

  assert_one_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strb));
  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (strb == '0));
  assert_alt_not_tf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_rd_o |-> !tf_rd_o && !we_i && size_i == 2'd0);
  assert_dp_index0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_wr_o || dp_rd_o) |-> (addr_i[11:4] == 8'd0) && (size_i != 2'd0));
  assert_rsvd_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd3) |-> (strb == '0));
  assert_rvalid_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  assert_reset_clear_R11: assert property (@(posedge clk_i)
    !rst_ni |-> (!rvalid_o && rdata_o == 32'h0));
endmodule

bind ide_swap_window ide_swap_window_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .size_i(size_i),
  .addr_i(32'(addr_i)), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
  .tf_wr_o(tf_wr_o), .tf_rd_o(tf_rd_o), .ctl_wr_o(ctl_wr_o), .alt_rd_o(alt_rd_o),
  .dp_wr_o(dp_wr_o), .dp_rd_o(dp_rd_o)
);

// File: tb/sim_ide_swap_window.sv
module sim_ide_swap_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [31:0] addr = '0, wdata = '0;
  logic        rvalid, tf_wr, tf_rd, ctl_wr, alt_rd, dp_wr, dp_rd, dp_wide;
  logic [2:0]  tf_idx;
  logic [31:0] rdata, dev_wdata, dev_rdata;

  int n_chk = 0, n_bad = 0;
  int strobe_cnt = 0, tf_rd_cnt = 0;

  logic [7:0]  tf_mem [8];
  logic [7:0]  ctl_reg;
  logic [31:0] dp_last;

  always #5 clk = ~clk;

  ide_swap_window u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata),
    .tf_wr_o(tf_wr), .tf_rd_o(tf_rd), .tf_idx_o(tf_idx), .ctl_wr_o(ctl_wr),
    .alt_rd_o(alt_rd), .dp_wr_o(dp_wr), .dp_rd_o(dp_rd), .dp_wide_o(dp_wide),
    .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata)
  );

  // responder: task-file bytes, control byte, fixed data-port patterns
  always_comb begin
    dev_rdata = 32'hA5A5_A5A5;
    if (tf_rd)  dev_rdata = {24'hA5A5A5, tf_mem[tf_idx]};
    if (alt_rd) dev_rdata = {24'hA5A5A5, tf_mem[7]};
    if (dp_rd)  dev_rdata = dp_wide ? 32'h1122_3344 : 32'hA5A5_5566;
  end

  always @(posedge clk) begin
    if (tf_wr)  tf_mem[tf_idx] <= dev_wdata[7:0];
    if (ctl_wr) ctl_reg <= dev_wdata[7:0];
    if (dp_wr)  dp_last <= dev_wdata;
    if (tf_wr | tf_rd | ctl_wr | alt_rd | dp_wr | dp_rd) strobe_cnt <= strobe_cnt + 1;
    if (tf_rd) tf_rd_cnt <= tf_rd_cnt + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [1:0] s, input logic [31:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; size = s; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  typedef struct packed {
    logic        w;
    logic [1:0]  s;
    logic [31:0] a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd0, 32'h0000_0020, 32'h0000_005A, 32'h0, 8'd2},  // R2 write idx2
    '{1'b0, 2'd0, 32'h0000_0020, 32'h0,         32'h5A, 8'd2}, // R2 read idx2
    '{1'b1, 2'd0, 32'h0000_0070, 32'h0000_00C8, 32'h0, 8'd2},  // R2 idx7
    '{1'b0, 2'd0, 32'h0000_0070, 32'h0,         32'hC8, 8'd2},
    '{1'b0, 2'd0, 32'h0000_0080, 32'h0,         32'hC8, 8'd3}, // R3 alias 8
    '{1'b0, 2'd0, 32'h0000_0160, 32'h0,         32'hC8, 8'd3}, // R3 alias 22
    '{1'b0, 2'd0, 32'h0000_0000, 32'h0,         32'hFF, 8'd4}, // R4 byte idx0
    '{1'b0, 2'd0, 32'h0000_0090, 32'h0,         32'hFF, 8'd4}, // R4 idx9
    '{1'b0, 2'd0, 32'h0000_0FF0, 32'h0,         32'hFF, 8'd4}, // R4 idx255
    '{1'b0, 2'd1, 32'h0000_0000, 32'h0,         32'h0000_6655, 8'd7}, // R7
    '{1'b0, 2'd2, 32'h0000_0000, 32'h0,         32'h4433_2211, 8'd8}, // R8
    '{1'b0, 2'd1, 32'h0000_0010, 32'h0,         32'h0000_FFFF, 8'd6}, // R6
    '{1'b0, 2'd2, 32'h0000_03F0, 32'h0,         32'hFFFF_FFFF, 8'd6},
    '{1'b0, 2'd3, 32'h0000_0000, 32'h0,         32'hFFFF_FFFF, 8'd9}, // R9
    '{1'b0, 2'd0, 32'h1234_5020, 32'h0,         32'h5A, 8'd1}, // R1 high bits
    '{1'b0, 2'd0, 32'h0000_002F, 32'h0,         32'h5A, 8'd1}, // R1 in-stride
    '{1'b0, 2'd2, 32'hFFFF_F00C, 32'h0,         32'h4433_2211, 8'd1},
    '{1'b0, 2'd0, 32'h0000_0150, 32'h0,         32'hFF, 8'd4}  // R4 idx21
  };

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int sc;
    logic [31:0] hold;
    for (int i = 0; i < 8; i++) tf_mem[i] = 8'h00;
    ctl_reg = 8'h00; dp_last = 32'h0;
    repeat (3) @(negedge clk);
    check("R11 rvalid in reset", {31'h0, rvalid}, 32'h0);
    check("R11 rdata in reset", rdata, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(TBL[i].w, TBL[i].s, TBL[i].a, TBL[i].d);
      if (!TBL[i].w) begin
        // negedge after the request edge: registered result present (R10)
        check($sformatf("R%0d vec %0d rvalid", TBL[i].rq, i), {31'h0, rvalid}, 32'h1);
        check($sformatf("R%0d vec %0d rdata", TBL[i].rq, i), rdata, TBL[i].exp);
      end
    end

    // R3 alternate status does not raise the task-file read strobe
    sc = tf_rd_cnt;
    access(1'b0, 2'd0, 32'h0000_0080, 32'h0);
    check("R3 alt read no tf_rd", sc, tf_rd_cnt);

    // R3 control write at both aliases
    access(1'b1, 2'd0, 32'h0000_0080, 32'h0000_330E);
    check("R3 ctl write idx8", {24'h0, ctl_reg}, 32'h0E);
    access(1'b1, 2'd0, 32'h0000_0160, 32'h0000_0004);
    check("R3 ctl write idx22", {24'h0, ctl_reg}, 32'h04);

    // R7 / R8 write swapping
    access(1'b1, 2'd1, 32'h0000_0000, 32'h1234_ABCD);
    check("R7 half write swap", dp_last, 32'h0000_CDAB);
    access(1'b1, 2'd2, 32'h0000_0000, 32'hDEAD_BEEF);
    check("R8 word write swap", dp_last, 32'hEFBE_ADDE);

    // R4 R6 R9 dropped writes: no strobe, stored state untouched
    sc = strobe_cnt;
    access(1'b1, 2'd0, 32'h0000_0000, 32'h0000_0077);
    access(1'b1, 2'd0, 32'h0000_0090, 32'h0000_0077);
    check("R4 dropped byte writes", strobe_cnt, sc);
    access(1'b1, 2'd1, 32'h0000_0010, 32'h0000_7777);
    access(1'b1, 2'd2, 32'h0000_0020, 32'h7777_7777);
    check("R6 dropped wide writes", strobe_cnt, sc);
    access(1'b1, 2'd3, 32'h0000_0000, 32'h7777_7777);
    check("R9 reserved size write", strobe_cnt, sc);
    check("R6 data port kept", dp_last, 32'hEFBE_ADDE);
    access(1'b0, 2'd0, 32'h0000_0020, 32'h0);
    check("R6 tf idx2 kept", rdata, 32'h5A);

    // R10 rdata holds across writes and idle cycles
    hold = rdata;
    access(1'b1, 2'd0, 32'h0000_0030, 32'h0000_0011);
    repeat (2) @(negedge clk);
    check("R10 rvalid low idle", {31'h0, rvalid}, 32'h0);
    check("R10 rdata held", rdata, hold);
    access(1'b0, 2'd0, 32'h0000_0030, 32'h0);
    check("R2 write then read idx3", rdata, 32'h11);

    // R12 strobe count equals accesses that reach a target
    sc = strobe_cnt;
    access(1'b0, 2'd2, 32'h0000_0000, 32'h0);
    access(1'b0, 2'd0, 32'h0000_0040, 32'h0);
    check("R12 one strobe per access", strobe_cnt, sc + 2);

    // R11 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R11 rvalid after reset", {31'h0, rvalid}, 32'h0);
    check("R11 rdata after reset", rdata, 32'h0);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule